// File: doc/BRIEF.md
# Receive Holding Queue with Break Insertion

This block is the small holding queue between a byte-level serial receiver and the register interface of a UART. Received bytes are stored in arrival order in a queue of `DEPTH` entries (four by default). The oldest stored byte is always shown on `head_data`, and a pop strobe from the register side consumes it. Every remaining entry then moves one place toward the head. Two status bits come from the queue's occupancy: `rx_ready` (at least one byte is held) and `fifo_full` (all entries are held). A receiver-reset strobe empties the queue.

When the line logic reports a break, the queue stores a 0x00 byte and sets a sticky break-change flag. A break is never lost. If the queue is already full, the zero byte overwrites the newest entry. Ordinary bytes are taken only while the receiver is enabled and the queue has room. The `can_accept` output tells the receiver when it may deliver a byte.

Occupancy is tracked by a three-state machine with the states Q_EMPTY, Q_PARTIAL and Q_FULL, together with an entry count. The named transitions are:

- grow: Q_EMPTY to Q_PARTIAL, or Q_PARTIAL to Q_FULL.
- drain: Q_FULL to Q_PARTIAL, or Q_PARTIAL to Q_EMPTY.
- hold: the state stays the same, including the case where a pop and a push happen together.
- flush: any state to Q_EMPTY on receiver reset.

Top module: `rx_hold_queue`

## Requirements
- R1: After `rst_n` is released, `rx_ready`, `fifo_full` and `brk_flag` are 0 and `head_data` is 0x00.
- R2: `can_accept` is 1 exactly when `rx_en` is 1 and `fifo_full` is 0.
- R3: A byte pushed while `rx_en` is 1 and the queue has room is stored behind the bytes already held. `rx_ready` is 1 on the cycle after the push. `head_data` always shows the oldest held byte.
- R4: `fifo_full` is 1 exactly when `DEPTH` bytes are held.
- R5: A push is discarded and leaves the held bytes unchanged in two cases: when `rx_en` is 0, or when the queue is full and no pop occurs in the same cycle.
- R6: `brk_evt` stores a 0x00 byte whether or not `rx_en` is set, and it takes precedence over a normal push in the same cycle, which is then discarded. If the queue is full after any same-cycle pop, the zero byte replaces the newest held byte and the count stays at `DEPTH`.
- R7: A pop of a non-empty queue removes the head byte and moves the rest toward the head. It clears `fifo_full`, and it clears `rx_ready` only when the queue becomes empty.
- R8: A pop and a push in the same cycle apply the pop first and then the push. This holds even when the queue is full, and the count is unchanged.
- R9: A pop of an empty queue leaves `rx_ready` and `fifo_full` at 0 and `head_data` at 0x00.
- R10: `rx_reset` empties the queue on the next edge. It takes precedence over a push, a pop or a break byte in the same cycle.
- R11: `brk_flag` is set on the cycle after `brk_evt` and holds until a `brk_clr` strobe. A `brk_clr` in the same cycle as `brk_evt` leaves the flag at 0. `rx_reset` does not touch the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; gates normal pushes |
| push_vld | input | 1 | A received byte is offered this cycle |
| push_data | input | DW | The received byte |
| brk_evt | input | 1 | Line break detected; inserts a 0x00 byte |
| pop | input | 1 | Register read of the head byte |
| rx_reset | input | 1 | Receiver reset; empties the queue |
| brk_clr | input | 1 | Clears the break-change flag |
| can_accept | output | 1 | Receiver may deliver a byte |
| rx_ready | output | 1 | At least one byte held |
| fifo_full | output | 1 | All entries held |
| head_data | output | DW | Oldest held byte, 0x00 when empty |
| brk_flag | output | 1 | Sticky break-change flag |

## Verification
The bench builds the block with its defaults, DEPTH=4 and DW=8. With only four entries, a random stream in which pushes outnumber pops reaches the full state within a few cycles. This makes the corner cases frequent: discarded pushes, pops and pushes together while full, and break bytes overwriting the newest entry. A small data width also lets the bench compare every byte that passes through the queue against its own model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } qstate_e;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          push_vld,
    input  logic [DW-1:0] push_data,
    input  logic          brk_evt,
    input  logic          pop,
    input  logic          rx_reset,
    output logic          shift,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic          rx_ready,
    output logic          fifo_full
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    qstate_e       state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt, cnt_mid;

    // Next count and write control: pop first, then break or push.
    always_comb begin
        shift   = pop && (cnt != '0) && !rx_reset;
        cnt_mid = shift ? cnt - 1'b1 : cnt;
        cnt_nxt = cnt_mid;
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_data = '0;
        if (rx_reset) begin
            cnt_nxt = '0;
        end else if (brk_evt) begin
            wr_en = 1'b1;
            if (cnt_mid == FULL_CNT) begin
                wr_idx = IW'(DEPTH - 1);
            end else begin
                wr_idx  = cnt_mid[IW-1:0];
                cnt_nxt = cnt_mid + 1'b1;
            end
        end else if (push_vld && rx_en && (cnt_mid != FULL_CNT)) begin
            wr_en   = 1'b1;
            wr_idx  = cnt_mid[IW-1:0];
            wr_data = push_data;
            cnt_nxt = cnt_mid + 1'b1;
        end
    end

    // Named transitions: grow, drain, hold, flush.
    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY: begin
                if (cnt_nxt == FULL_CNT)  state_nxt = Q_FULL;
                else if (cnt_nxt != '0)   state_nxt = Q_PARTIAL;
            end
            Q_PARTIAL: begin
                if (cnt_nxt == '0)           state_nxt = Q_EMPTY;
                else if (cnt_nxt == FULL_CNT) state_nxt = Q_FULL;
            end
            Q_FULL: begin
                if (cnt_nxt == '0)           state_nxt = Q_EMPTY;
                else if (cnt_nxt != FULL_CNT) state_nxt = Q_PARTIAL;
            end
            default: state_nxt = Q_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= Q_EMPTY;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Status outputs.
    always_comb begin
        rx_ready  = 1'b0;
        fifo_full = 1'b0;
        unique case (state)
            Q_EMPTY:   ;
            Q_PARTIAL: rx_ready = 1'b1;
            Q_FULL: begin
                rx_ready  = 1'b1;
                fifo_full = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          shift,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] head
);
    logic [DW-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DW-1:0] moved;
        if (i == DEPTH - 1) begin : g_tail
            assign moved = shift ? '0 : ent[i];
        end else begin : g_body
            assign moved = shift ? ent[i+1] : ent[i];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                ent[i] <= '0;
            else if (clear)                            ent[i] <= '0;
            else if (wr_en && (wr_idx == IW'(i)))      ent[i] <= wr_data;
            else                                       ent[i] <= moved;
        end
    end

    assign head = ent[0];
endmodule

// File: rtl/rxq_brk.sv
module rxq_brk (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_evt,
    input  logic brk_clr,
    output logic brk_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       brk_flag <= 1'b0;
        else if (brk_clr) brk_flag <= 1'b0;
        else if (brk_evt) brk_flag <= 1'b1;
    end
endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          push_vld,
    input  logic [DW-1:0] push_data,
    input  logic          brk_evt,
    input  logic          pop,
    input  logic          rx_reset,
    input  logic          brk_clr,
    output logic          can_accept,
    output logic          rx_ready,
    output logic          fifo_full,
    output logic [DW-1:0] head_data,
    output logic          brk_flag
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          shift, wr_en;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data;

    rxq_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .push_vld(push_vld),
        .push_data(push_data), .brk_evt(brk_evt), .pop(pop),
        .rx_reset(rx_reset), .shift(shift), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rx_ready(rx_ready), .fifo_full(fifo_full)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(rx_reset), .shift(shift),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .head(head_data)
    );

    rxq_brk u_brk (
        .clk(clk), .rst_n(rst_n), .brk_evt(brk_evt), .brk_clr(brk_clr),
        .brk_flag(brk_flag)
    );

    assign can_accept = rx_en && !fifo_full;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          push_vld,
    input logic          brk_evt,
    input logic          pop,
    input logic          rx_reset,
    input logic          brk_clr,
    input logic          can_accept,
    input logic          rx_ready,
    input logic          fifo_full,
    input logic [DW-1:0] head_data,
    input logic          brk_flag
);
    p_accept_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        can_accept |-> (rx_en && !fifo_full));

    p_full_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> rx_ready);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && push_vld && !pop && !brk_evt && !rx_reset)
        |=> (fifo_full && $stable(head_data)));

    p_brk_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt && !rx_reset && !rx_ready) |=> (rx_ready && head_data == '0));

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && pop && !push_vld && !brk_evt)
        |=> (!rx_ready && !fifo_full && head_data == '0));

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> (!rx_ready && !fifo_full && head_data == '0));

    p_brk_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt && !brk_clr) |=> brk_flag);

    p_brk_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_clr |=> !brk_flag);

    p_brk_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !brk_clr) |=> brk_flag);
endmodule

bind rx_hold_queue rxq_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .push_vld(push_vld),
    .brk_evt(brk_evt), .pop(pop), .rx_reset(rx_reset), .brk_clr(brk_clr),
    .can_accept(can_accept), .rx_ready(rx_ready), .fifo_full(fifo_full),
    .head_data(head_data), .brk_flag(brk_flag)
);

// File: tb/rx_hold_queue_test.sv
`timescale 1ns/1ps
module rx_hold_queue_test;
    localparam int D = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, push_vld = 1'b0, brk_evt = 1'b0, pop = 1'b0;
    logic       rx_reset = 1'b0, brk_clr = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       can_accept, rx_ready, fifo_full, brk_flag;
    logic [7:0] head_data;

    int errors = 0;
    int checks = 0;
    logic [7:0] mq [D];
    int mn = 0;
    bit mflag = 0;

    always #10 clk = ~clk;

    rx_hold_queue #(.DEPTH(D), .DW(8)) uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .push_vld(push_vld),
        .push_data(push_data), .brk_evt(brk_evt), .pop(pop),
        .rx_reset(rx_reset), .brk_clr(brk_clr), .can_accept(can_accept),
        .rx_ready(rx_ready), .fifo_full(fifo_full), .head_data(head_data),
        .brk_flag(brk_flag)
    );

    function automatic int exp_head();
        return (mn > 0) ? int'(mq[0]) : 0;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "head_data (R3)", int'(head_data), exp_head());
        chk(tag, "rx_ready (R7)", int'(rx_ready), int'(mn > 0));
        chk(tag, "fifo_full (R4)", int'(fifo_full), int'(mn == D));
        chk(tag, "can_accept (R2)", int'(can_accept), int'(rx_en && mn != D));
        chk(tag, "brk_flag (R11)", int'(brk_flag), int'(mflag));
    endtask

    // Bench model of one clock edge.
    task automatic model_edge();
        if (rx_reset) begin
            mn = 0;
        end else begin
            if (pop && mn > 0) begin
                for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
                mn--;
            end
            if (brk_evt) begin
                if (mn == D) mq[D-1] = 8'h00;
                else begin mq[mn] = 8'h00; mn++; end
            end else if (push_vld && rx_en && mn < D) begin
                mq[mn] = push_data;
                mn++;
            end
        end
        if (brk_evt) mflag = 1;
        if (brk_clr) mflag = 0;
    endtask

    task automatic step(input string tag, input bit en, input bit pv, input logic [7:0] d,
                        input bit bk, input bit pp, input bit rr, input bit cl);
        rx_en = en; push_vld = pv; push_data = d; brk_evt = bk;
        pop = pp; rx_reset = rr; brk_clr = cl;
        #1;
        chk(tag, "can_accept before edge (R2)", int'(can_accept), int'(en && mn != D));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R3/R4: fill in order
        step("R3 push a", 1, 1, 8'h11, 0, 0, 0, 0);
        step("R3 push b", 1, 1, 8'h22, 0, 0, 0, 0);
        step("R3 push c", 1, 1, 8'h33, 0, 0, 0, 0);
        step("R4 push d full", 1, 1, 8'h44, 0, 0, 0, 0);
        // R5: push while full is dropped
        step("R5 push on full", 1, 1, 8'h55, 0, 0, 0, 0);
        // R8: pop and push together while full
        step("R8 pop+push full", 1, 1, 8'h66, 0, 1, 0, 0);
        // R6: break on full overwrites newest
        step("R6 break on full", 1, 0, 8'h00, 1, 0, 0, 0);
        // R7: drain in order, zero last
        step("R7 pop 1", 1, 0, 8'h00, 0, 1, 0, 0);
        step("R7 pop 2", 1, 0, 8'h00, 0, 1, 0, 0);
        chk("R6 overwritten byte", "head_data", int'(head_data), 8'h44);
        step("R7 pop 3", 1, 0, 8'h00, 0, 1, 0, 0);
        chk("R6 zero at tail", "head_data", int'(head_data), 0);
        step("R7 pop 4 empty", 1, 0, 8'h00, 0, 1, 0, 0);
        // R9: pop on empty
        step("R9 pop empty", 1, 0, 8'h00, 0, 1, 0, 0);
        // R5: push while disabled
        step("R5 push disabled", 0, 1, 8'h77, 0, 0, 0, 0);
        // R6: break ignores enable, wins over push
        step("R6 break disabled", 0, 0, 8'h00, 1, 0, 0, 0);
        step("R6 break vs push", 1, 1, 8'h88, 1, 0, 0, 0);
        // R11: flag holds, then clear; clear wins over same-cycle break
        step("R11 flag hold", 1, 0, 8'h00, 0, 0, 0, 0);
        step("R11 clear", 1, 0, 8'h00, 0, 0, 0, 1);
        step("R11 clear beats break", 1, 0, 8'h00, 1, 0, 0, 1);
        // R10: receiver reset beats push and pop; flag untouched
        step("R10 set flag", 1, 1, 8'h99, 1, 0, 0, 0);
        step("R10 flush", 1, 1, 8'hAA, 1, 1, 1, 0);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            bit en, pv, bk, pp, rr, cl;
            en = ($urandom_range(99) < 85);
            pv = ($urandom_range(99) < 60);
            bk = ($urandom_range(99) < 5);
            pp = ($urandom_range(99) < 35);
            rr = ($urandom_range(99) < 2);
            cl = ($urandom_range(99) < 10);
            step("R3/R7 random", en, pv, 8'($urandom), bk, pp, rr, cl);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule